// File: doc/BRIEF.md
# Watchdog Counter with Sleep-Resume Gating

This block is the watchdog of a microcontroller that runs from two clock sources: an internal ring oscillator and an external crystal. The watchdog advances only on crystal clock enables (`xtalTick`), all modelled in a single clock domain. When it wraps past its top value, it sends a one-cycle reset pulse to the system. Software keeps it from expiring by writing a fixed key value, which returns the count to zero.

When a deep-sleep request is accepted, the watchdog freezes with its count intact. When the chip wakes, a stabilization counter starts from zero on crystal ticks. Its length is one of eight power-of-two durations chosen by a 3-bit select value. The watchdog stays frozen until one of two things happens, whichever is first: the stabilization time runs out, or the CPU reports that it has switched onto the crystal clock. It then continues from the held count. The CPU is released a fixed number of cycles after wake, and the elapsed stabilization count is available as status for software.

Top module: `stopgate_wdt`

## Requirements
- R1: After hardware reset the outputs are as follows. `count` is 0, `frozen` is 0, `stabCount` is 0, `cpuRun` is 1 and `wdtReset` is 0. A reset taken while asleep also clears the freeze.
- R2: While not frozen, `count` increases by one at each clock edge where `xtalTick` is 1. It holds at edges where `xtalTick` is 0.
- R3: A `stopReq` accepted while running sets `frozen` at that edge. From then on `count` holds for as long as `frozen` is 1.
- R4: The edge that sees `wakeEvt` while asleep zeroes `stabCount`. The count then advances on each `xtalTick` up to T = 2^(STAB_MIN_LOG + `stabSel`). With a crystal tick every cycle and no clock switch, `frozen` falls at the (T+1)-th edge after the wake edge, and `stabCount` then reads T.
- R5: `clkSwitchDone` seen during stabilization clears `frozen` at that same edge, if this comes before the stabilization timeout. A switch arriving after resume has no effect.
- R6: On resume `count` still holds the value it had while frozen. It is not cleared.
- R7: When `count` is at its all-ones value and a counting tick arrives, `count` becomes 0 and `wdtReset` is 1 for exactly one cycle.
- R8: A cycle with `clrWrEn`=1 and `clrData` equal to CLR_KEY (default 8'hA5) zeroes `count` at that edge. Any other `clrData` value is ignored, and counting continues.
- R9: A key clear taken while frozen zeroes `count` at once. `frozen` stays 1 until the normal resume condition.
- R10: `stopReq` while already frozen has no effect. Stabilization is not restarted and resume timing is unchanged.
- R11: `cpuRun` falls when sleep is entered. It rises at the CPU_WAKE_DLY-th edge (default 17) after the wake edge, independently of the watchdog freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| xtalTick | input | 1 | Crystal clock enable |
| stopReq | input | 1 | Deep-sleep entry request pulse |
| wakeEvt | input | 1 | Wake (sleep release) pulse |
| clkSwitchDone | input | 1 | CPU has moved onto the crystal clock |
| stabSel | input | SEL_W | Stabilization duration select |
| clrWrEn | input | 1 | Clear-key write strobe |
| clrData | input | KEY_W | Clear-key write data |
| count | output | CNT_W | Watchdog count |
| wdtReset | output | 1 | One-cycle overflow reset pulse |
| frozen | output | 1 | Watchdog is held (asleep or stabilizing) |
| cpuRun | output | 1 | CPU is allowed to run |
| stabCount | output | STAB_W | Elapsed stabilization ticks (status) |

## Verification
The bench builds the block with CNT_W=8 and STAB_MIN_LOG=2. An overflow then takes 256 counting cycles, and the stabilization durations span 4 to 512 ticks. With these values every select setting, including the longest, fits in a short run. It also brings within reach the cases where the 17-cycle CPU release lands before the watchdog resumes and the cases where it lands after. A table of sleep and wake scenarios varies the select value and the timing of clock-switch and repeated sleep requests. Directed tests cover overflow, key clears, gated ticks and reset while asleep.

// File: rtl/stopgate_wdt_pkg.sv
package stopgate_wdt_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_SLEEP  = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;

  typedef struct packed {
    logic cntEn;    // advance watchdog
    logic cntClr;   // zero watchdog
    logic stabClr;  // restart stabilization count
    logic stabEn;   // advance stabilization count
  } strobe_t;
endpackage

// File: rtl/stopgate_wdt_dp.sv
module stopgate_wdt_dp
  import stopgate_wdt_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SEL_W        = 3,
  parameter int STAB_MIN_LOG = 11,
  parameter int STAB_W       = STAB_MIN_LOG + (2 ** SEL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SEL_W-1:0]  stabSel,
  output logic [CNT_W-1:0]  count,
  output logic              wdtReset,
  output logic [STAB_W-1:0] stabCount,
  output logic              stabDone
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [STAB_W-1:0] stabTarget;
  logic              atTop;

  assign stabTarget = STAB_W'(1) << (STAB_MIN_LOG + int'(stabSel));
  assign stabDone   = (stabCount >= stabTarget);
  assign atTop      = (count == CNT_MAX);

  // watchdog count and overflow pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      wdtReset <= 1'b0;
    end else if (strb.cntClr) begin
      count    <= '0;
      wdtReset <= 1'b0;
    end else if (strb.cntEn) begin
      count    <= atTop ? '0 : count + 1'b1;
      wdtReset <= atTop;
    end else begin
      wdtReset <= 1'b0;
    end
  end

  // stabilization counter, saturates once the target is reached
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stabCount <= '0;
    else if (strb.stabClr)
      stabCount <= '0;
    else if (strb.stabEn && !stabDone)
      stabCount <= stabCount + 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntEn && !strb.cntClr) |=> $stable(count));
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |-> (count == '0));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> !wdtReset);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (count == '0));
endmodule

// File: rtl/stopgate_wdt_ctrl.sv
module stopgate_wdt_ctrl
  import stopgate_wdt_pkg::*;
#(
  parameter int          KEY_W        = 8,
  parameter logic [KEY_W-1:0] CLR_KEY = 8'hA5,
  parameter int          CPU_WAKE_DLY = 17,
  parameter int          DLY_W        = $clog2(CPU_WAKE_DLY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalTick,
  input  logic             stopReq,
  input  logic             wakeEvt,
  input  logic             clkSwitchDone,
  input  logic             clrWrEn,
  input  logic [KEY_W-1:0] clrData,
  input  logic             stabDone,
  output strobe_t          strb,
  output logic             frozen,
  output logic             cpuRun
);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(CPU_WAKE_DLY);

  phase_t           phase;
  logic             cpuHold;
  logic [DLY_W-1:0] wakeCnt;

  always_comb begin
    strb.cntEn   = (phase == PH_RUN) && xtalTick;
    strb.cntClr  = clrWrEn && (clrData == CLR_KEY);
    strb.stabClr = (phase == PH_SLEEP) && wakeEvt;
    strb.stabEn  = (phase == PH_SETTLE) && xtalTick;
  end

  assign frozen = (phase != PH_RUN);
  assign cpuRun = !cpuHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_RUN;
    end else begin
      case (phase)
        PH_RUN:    if (stopReq) phase <= PH_SLEEP;
        PH_SLEEP:  if (wakeEvt) phase <= PH_SETTLE;
        PH_SETTLE: if (clkSwitchDone || stabDone) phase <= PH_RUN;
        default:   phase <= PH_RUN;
      endcase
    end
  end

  // CPU release a fixed delay after wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuHold <= 1'b0;
      wakeCnt <= '0;
    end else if (phase == PH_RUN && stopReq) begin
      cpuHold <= 1'b1;
      wakeCnt <= '0;
    end else if (phase == PH_SLEEP && wakeEvt) begin
      wakeCnt <= DLY_LOAD;
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - 1'b1;
      if (wakeCnt == DLY_W'(1)) cpuHold <= 1'b0;
    end
  end

  assert_stop_freezes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && stopReq) |=> frozen);
  assert_switch_resumes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETTLE && clkSwitchDone) |=> !frozen);
  assert_refreeze_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETTLE && stopReq && !clkSwitchDone && !stabDone) |=> (phase == PH_SETTLE));
  assert_cpu_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SLEEP) |-> !cpuRun);
endmodule

// File: rtl/stopgate_wdt.sv
module stopgate_wdt
  import stopgate_wdt_pkg::*;
#(
  parameter int          CNT_W        = 16,
  parameter int          SEL_W        = 3,
  parameter int          STAB_MIN_LOG = 11,
  parameter int          KEY_W        = 8,
  parameter logic [KEY_W-1:0] CLR_KEY = 8'hA5,
  parameter int          CPU_WAKE_DLY = 17,
  parameter int          STAB_W       = STAB_MIN_LOG + (2 ** SEL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalTick,
  input  logic              stopReq,
  input  logic              wakeEvt,
  input  logic              clkSwitchDone,
  input  logic [SEL_W-1:0]  stabSel,
  input  logic              clrWrEn,
  input  logic [KEY_W-1:0]  clrData,
  output logic [CNT_W-1:0]  count,
  output logic              wdtReset,
  output logic              frozen,
  output logic              cpuRun,
  output logic [STAB_W-1:0] stabCount
);
  strobe_t strb;
  logic    stabDone;

  stopgate_wdt_ctrl #(
    .KEY_W(KEY_W), .CLR_KEY(CLR_KEY), .CPU_WAKE_DLY(CPU_WAKE_DLY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .stopReq(stopReq),
    .wakeEvt(wakeEvt), .clkSwitchDone(clkSwitchDone), .clrWrEn(clrWrEn),
    .clrData(clrData), .stabDone(stabDone), .strb(strb), .frozen(frozen),
    .cpuRun(cpuRun)
  );

  stopgate_wdt_dp #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .STAB_MIN_LOG(STAB_MIN_LOG), .STAB_W(STAB_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .stabSel(stabSel), .count(count),
    .wdtReset(wdtReset), .stabCount(stabCount), .stabDone(stabDone)
  );
endmodule

// File: tb/stopgate_wdt_test.sv
module stopgate_wdt_test;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int MINL  = 2;
  localparam int STW   = MINL + (2 ** SEL_W);

  typedef struct packed {
    int sel; int swAt; int stopAt; int expK;
  } vec_t;
  // resume edge = min(swAt, 2^(MINL+sel)+1); swAt 0 = none
  localparam vec_t VECS [8] = '{
    '{0, 0, 0, 5},    // R4
    '{1, 0, 0, 9},    // R4
    '{3, 0, 0, 33},   // R4
    '{2, 3, 0, 3},    // R5
    '{1, 0, 3, 9},    // R10
    '{7, 0, 0, 513},  // R4 R11
    '{7, 40, 0, 40},  // R5 R11
    '{0, 9, 0, 5}     // R5 switch after resume
  };

  logic clk = 0, rstN = 0, xtalTick = 1, stopReq = 0, wakeEvt = 0;
  logic clkSwitchDone = 0, clrWrEn = 0;
  logic [SEL_W-1:0] stabSel = '0;
  logic [7:0] clrData = '0;
  logic [CNT_W-1:0] count;
  logic wdtReset, frozen, cpuRun;
  logic [STW-1:0] stabCount;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stopgate_wdt #(.CNT_W(CNT_W), .SEL_W(SEL_W), .STAB_MIN_LOG(MINL)) uut (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .stopReq(stopReq),
    .wakeEvt(wakeEvt), .clkSwitchDone(clkSwitchDone), .stabSel(stabSel),
    .clrWrEn(clrWrEn), .clrData(clrData), .count(count), .wdtReset(wdtReset),
    .frozen(frozen), .cpuRun(cpuRun), .stabCount(stabCount)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next posedge
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulseClear(logic [7:0] key);
    @(negedge clk); clrWrEn = 1; clrData = key;
    cyc();
    @(negedge clk); clrWrEn = 0;
  endtask

  task automatic goSleep(output int held);
    @(negedge clk); stopReq = 1;
    cyc(); held = count;
    @(negedge clk); stopReq = 0;
  endtask

  task automatic goWake();
    @(negedge clk); wakeEvt = 1;
    cyc();
    @(negedge clk); wakeEvt = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held, c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0); chk("R1 frozen", frozen, 0);
    chk("R1 cpuRun", cpuRun, 1); chk("R1 stabCount", stabCount, 0);
    chk("R1 wdtReset", wdtReset, 0);
    @(negedge clk); rstN = 1;

    // table of sleep/wake scenarios
    foreach (VECS[i]) begin
      int resumeK, cpuK;
      pulseClear(8'hA5);
      repeat (3) cyc();
      stabSel = VECS[i].sel[SEL_W-1:0];
      goSleep(held);
      chk("R3 frozen on stop", frozen, 1);
      repeat (4) cyc();
      chk("R3 count held", count, held);
      goWake();
      resumeK = 0; cpuK = 0;
      for (int k = 1; k <= 600; k++) begin
        clkSwitchDone = (k == VECS[i].swAt);
        stopReq = (k == VECS[i].stopAt);
        cyc();
        if (cpuRun && cpuK == 0) cpuK = k;
        if (!frozen) begin resumeK = k; break; end
        @(negedge clk);
      end
      @(negedge clk); clkSwitchDone = 0; stopReq = 0;
      chk($sformatf("R4/R5/R10 resume edge vec%0d", i), resumeK, VECS[i].expK);
      chk("R6 count kept", count, held);
      if (VECS[i].swAt == 0)
        chk("R4 stabCount", stabCount, 1 << (MINL + VECS[i].sel));
      if (VECS[i].expK >= 17) chk("R11 cpu release", cpuK, 17);
      cyc();
      chk("R2 counts after resume", count, (held + 1) % 256);
      if (VECS[i].swAt > VECS[i].expK) begin
        // R5 late switch ignored
        @(negedge clk); clkSwitchDone = 1; cyc();
        @(negedge clk); clkSwitchDone = 0;
        chk("R5 late switch no effect", frozen, 0);
      end
    end

    // R7 overflow
    pulseClear(8'hA5);
    chk("R8 key clears", count, 0);
    begin
      int hitK = 0;
      for (int k = 1; k <= 300; k++) begin
        cyc();
        if (wdtReset) begin hitK = k; break; end
      end
      chk("R7 overflow edge", hitK, 256);
      chk("R7 wrap to zero", count, 0);
      cyc();
      chk("R7 single pulse", wdtReset, 0);
      chk("R7 counts on", count, 1);
    end

    // R8 wrong key ignored
    c0 = count;
    pulseClear(8'h5A);
    chk("R8 wrong key ignored", count, (c0 + 1) % 256);

    // R2 gated ticks
    @(negedge clk); xtalTick = 0; c0 = count;
    repeat (5) cyc();
    chk("R2 hold without tick", count, c0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); xtalTick = k[0];
      cyc();
    end
    chk("R2 gated count", count, (c0 + 5) % 256);
    @(negedge clk); xtalTick = 1;

    // R9 clear while frozen
    stabSel = 0;
    repeat (5) cyc();
    goSleep(held);
    pulseClear(8'hA5);
    chk("R9 clear while frozen", count, 0);
    repeat (3) cyc();
    chk("R9 still frozen", frozen, 1);
    chk("R9 stays zero", count, 0);
    goWake();
    repeat (5) cyc();
    chk("R9 resumed", frozen, 0);

    // R1 reset while asleep
    goSleep(held);
    @(negedge clk); rstN = 0;
    #1;
    chk("R1 reset frozen", frozen, 0);
    chk("R1 reset count", count, 0);
    chk("R1 reset cpuRun", cpuRun, 1);
    chk("R1 reset stabCount", stabCount, 0);
    @(negedge clk); rstN = 1;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule